// File: doc/BRIEF.md
# Trace Stimulus Port Access Controller

This block is the register front end of a software-driven trace source. It has 32 stimulus ports, each a 32-bit word on a simple register bus. A write to a stimulus port forwards the written word to a downstream trace packet queue, tagged with its port number. The forward happens only if the port may accept it. Three configuration registers control that gating: a per-port enable mask, a privilege mask with one bit per group of eight ports, and a control word whose bit 0 is the master enable.

Each bus cycle carries the requester's privilege level. The privilege level only restricts writes. Reading a stimulus port is always allowed and returns a ready flag. Configuration state changes only on privileged writes. A stimulus write that the gating refuses completes in the same cycle, with no error and no wait. The only case that holds the bus is an accepted write while the one-entry output stage is still occupied. In that case `bus_wait` stays high until the queue takes the pending entry.

Top module: `trc_stim_ctrl`

## Requirements
- R1: After reset the enable mask, privilege mask and control word read as zero, and `q_valid` is low.
- R2: Byte addresses 0x000–0x07C select stimulus port `addr[6:2]`. An accepted write appears on `q_port`/`q_data` with that port number and the written word. Reads of addresses that map to nothing return zero. Address bits [1:0] are ignored.
- R3: The enable mask is at 0x100, with bit n enabling port n. A write to a port whose bit is clear is dropped.
- R4: The control word is at 0x180, with bit 0 as the master enable. While it is 0, every stimulus write is dropped and completes with `bus_wait` low.
- R5: The privilege mask is at 0x140, and bit g covers ports 8g to 8g+7. When bit g is set, unprivileged writes to those ports are dropped. Privileged writes to them are still accepted.
- R6: A stimulus port read returns bit 0 = 1 exactly when a new write would be taken without waiting (output stage empty, or `q_ready` high). All other bits read as zero. The privilege level and the privilege mask have no effect on this read.
- R7: An unprivileged read of the enable mask returns only the enable bits of groups whose privilege bit is clear. All other bits read as zero. A privileged read returns the full mask.
- R8: The enable mask, privilege mask and control word change only on privileged writes. Unprivileged writes to them are ignored.
- R9: An accepted stimulus write while the output stage holds an entry and `q_ready` is low raises `bus_wait` until the entry is taken. A held entry keeps `q_port`/`q_data` stable. Entries leave in the order they were written.
- R10: A dropped stimulus write never raises `bus_wait`, even while the output stage is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | Requester is privileged |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_wait | output | 1 | Access must be held another cycle |
| q_valid | output | 1 | Output stage holds a stimulus entry |
| q_ready | input | 1 | Queue takes the entry this cycle |
| q_port | output | 5 | Port number of the entry |
| q_data | output | 32 | Data word of the entry |

## Verification
The bench uses a write with the output stage full and `q_ready` low to check that the bus stalls, and that the data is forwarded in order once the queue drains. A design without that stall would overwrite the pending entry or lose the second write. A write to a disabled port issued under the same full condition must still finish at once; a design that gated the stall wrongly would hang the bus. Unprivileged accesses check several cases: a group-locked port, a configuration register, and a stimulus read. A design that applied privilege to reads would return zero for the stimulus read, and one that lacked the write lock would let unprivileged code rewrite the masks. Reading the enable mask without privilege checks the per-group masking, and reading an unmapped address checks the zero default.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned NPORTS  = 32;
  localparam int unsigned GROUP   = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned PORT_W  = $clog2(NPORTS);

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_STIM,
    TGT_EN,
    TGT_PRIV,
    TGT_CTRL
  } tgt_e;
endpackage

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PW = PORT_W,
  parameter logic [AW-1:0] EN_ADDR   = 'h100,
  parameter logic [AW-1:0] PRIV_ADDR = 'h140,
  parameter logic [AW-1:0] CTRL_ADDR = 'h180
) (
  input  logic [AW-1:0] addr,
  output tgt_e          tgt,
  output logic [PW-1:0] port
);
  logic [AW-1:0] word_addr;

  assign word_addr = {addr[AW-1:2], 2'b00};
  assign port      = addr[PW+1:2];

  always_comb begin
    tgt = TGT_NONE;
    if (addr[AW-1:PW+2] == '0) begin
      tgt = TGT_STIM;
    end else begin
      if (word_addr == EN_ADDR)   tgt = TGT_EN;
      if (word_addr == PRIV_ADDR) tgt = TGT_PRIV;
      if (word_addr == CTRL_ADDR) tgt = TGT_CTRL;
    end
  end
endmodule

// File: rtl/trc_cfg.sv
module trc_cfg
  import trc_pkg::*;
#(
  parameter int unsigned NP = NPORTS,
  parameter int unsigned GS = GROUP,
  parameter int unsigned DW = DATA_W,
  localparam int unsigned PW = $clog2(NP),
  localparam int unsigned NG = NP / GS,
  localparam int unsigned GSH = $clog2(GS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          priv,
  input  tgt_e          tgt,
  input  logic [PW-1:0] port,
  input  logic [DW-1:0] wdata,
  output logic          stim_ok,
  output logic          glob_en,
  output logic [DW-1:0] cfg_rdata
);
  logic [NP-1:0] en_q, en_d, en_vis;
  logic [NG-1:0] lock_q, lock_d;
  logic          gen_q, gen_d;
  logic          cfg_wr, en_we, lock_we, gen_we;
  logic [PW-GSH-1:0] grp;

  assign cfg_wr  = wr_stb && priv;
  assign en_we   = cfg_wr && (tgt == TGT_EN);
  assign lock_we = cfg_wr && (tgt == TGT_PRIV);
  assign gen_we  = cfg_wr && (tgt == TGT_CTRL);

  always_comb begin
    en_d   = wdata[NP-1:0];
    lock_d = wdata[NG-1:0];
    gen_d  = wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lock_q <= '0;
      gen_q  <= 1'b0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (lock_we) lock_q <= lock_d;
      if (gen_we)  gen_q  <= gen_d;
    end
  end

  assign grp     = port[PW-1:GSH];
  assign stim_ok = gen_q && en_q[port] && (priv || !lock_q[grp]);
  assign glob_en = gen_q;

  for (genvar g = 0; g < NG; g++) begin : g_vis
    assign en_vis[g*GS +: GS] = (priv || !lock_q[g]) ? en_q[g*GS +: GS] : '0;
  end

  always_comb begin
    cfg_rdata = '0;
    case (tgt)
      TGT_EN:   cfg_rdata[NP-1:0] = en_vis;
      TGT_PRIV: cfg_rdata[NG-1:0] = lock_q;
      TGT_CTRL: cfg_rdata[0]      = gen_q;
      default:  cfg_rdata         = '0;
    endcase
  end

  // R8: unprivileged writes leave all configuration state untouched
  p_cfg_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !priv) |=> ($stable(en_q) && $stable(lock_q) && $stable(gen_q)));
endmodule

// File: rtl/trc_out.sv
module trc_out
  import trc_pkg::*;
#(
  parameter int unsigned PW = PORT_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_port,
  input  logic [DW-1:0] push_data,
  input  logic          q_ready,
  output logic          q_valid,
  output logic [PW-1:0] q_port,
  output logic [DW-1:0] q_data,
  output logic          can_take
);
  logic          v_q, v_d, load;
  logic [PW-1:0] port_q;
  logic [DW-1:0] data_q;

  assign can_take = !v_q || q_ready;
  assign load     = push && can_take;

  always_comb begin
    v_d = v_q;
    if (load)         v_d = 1'b1;
    else if (q_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      port_q <= '0;
      data_q <= '0;
    end else begin
      v_q <= v_d;
      if (load) begin
        port_q <= push_port;
        data_q <= push_data;
      end
    end
  end

  assign q_valid = v_q;
  assign q_port  = port_q;
  assign q_data  = data_q;

  // R9: a held entry stays put until the queue takes it
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> (q_valid && $stable(q_port) && $stable(q_data)));
endmodule

// File: rtl/trc_stim_ctrl.sv
module trc_stim_ctrl
  import trc_pkg::*;
#(
  parameter int unsigned NP = NPORTS,
  parameter int unsigned GS = GROUP,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  localparam int unsigned PW = $clog2(NP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_priv,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_wait,
  output logic          q_valid,
  input  logic          q_ready,
  output logic [PW-1:0] q_port,
  output logic [DW-1:0] q_data
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  tgt_e          tgt;
  logic [PW-1:0] port;
  logic          wr_stb, stim_ok, glob_en, push, can_take;
  logic [DW-1:0] cfg_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  trc_decode #(.AW(AW), .PW(PW)) u_dec (
    .addr (bus_addr),
    .tgt  (tgt),
    .port (port)
  );

  assign wr_stb = bus_sel && bus_wr;

  trc_cfg #(.NP(NP), .GS(GS), .DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_stb    (wr_stb),
    .priv      (bus_priv),
    .tgt       (tgt),
    .port      (port),
    .wdata     (bus_wdata),
    .stim_ok   (stim_ok),
    .glob_en   (glob_en),
    .cfg_rdata (cfg_rdata)
  );

  assign push     = wr_stb && (tgt == TGT_STIM) && stim_ok;
  assign bus_wait = push && !can_take;

  trc_out #(.PW(PW), .DW(DW)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (push),
    .push_port (port),
    .push_data (bus_wdata),
    .q_ready   (q_ready),
    .q_valid   (q_valid),
    .q_port    (q_port),
    .q_data    (q_data),
    .can_take  (can_take)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (tgt == TGT_STIM) bus_rdata[0] = can_take;
      else                 bus_rdata    = cfg_rdata;
    end
  end

  // R9: a stall only happens while an entry is pending and not taken
  p_wait_full_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_wait |-> (bus_sel && bus_wr && q_valid && !q_ready));

  // R4: master-disabled writes never stall
  p_gdis_nowait_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_stb && !glob_en) |-> !bus_wait);

  // R6: stimulus reads return only the ready flag
  p_stim_read_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_sel && !bus_wr && tgt == TGT_STIM) |->
      (bus_rdata[DW-1:1] == '0 && bus_rdata[0] == (!q_valid || q_ready)));
endmodule

// File: tb/tb_trc_stim_ctrl.sv
module tb_trc_stim_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        bus_sel, bus_wr, bus_priv;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_wait, q_valid, q_ready;
  logic [4:0]  q_port;
  logic [31:0] q_data;

  int tests = 0;
  int fails = 0;
  bit mon_on = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_en;
  logic [3:0]  m_lock;
  logic        m_gen, m_ov;
  logic [4:0]  m_port;
  logic [31:0] m_data;

  trc_stim_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wait(bus_wait), .q_valid(q_valid),
    .q_ready(q_ready), .q_port(q_port), .q_data(q_data)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_stim(logic [11:0] a);
    return a[11:7] == 5'd0;
  endfunction

  function automatic bit accepts(logic priv, logic [4:0] p);
    return m_gen && m_en[p] && (priv || !m_lock[p[4:3]]);
  endfunction

  function automatic logic [31:0] exp_rdata();
    logic [31:0] mask;
    logic [11:0] w;
    w = {bus_addr[11:2], 2'b00};
    for (int g = 0; g < 4; g++)
      mask[g*8 +: 8] = (bus_priv || !m_lock[g]) ? 8'hFF : 8'h00;
    if (is_stim(bus_addr)) return {31'd0, (!m_ov || q_ready)};
    if (w == 12'h100) return m_en & mask;
    if (w == 12'h140) return {28'd0, m_lock};
    if (w == 12'h180) return {31'd0, m_gen};
    return 32'd0;
  endfunction

  function automatic logic exp_wait();
    return bus_sel && bus_wr && is_stim(bus_addr) &&
           accepts(bus_priv, bus_addr[6:2]) && m_ov && !q_ready;
  endfunction

  // behavioural reference, updated on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_lock = 0; m_gen = 0; m_ov = 0; m_port = 0; m_data = 0;
    end else begin
      bit ld;
      ld = 0;
      if (bus_sel && bus_wr) begin
        if (is_stim(bus_addr)) begin
          if (accepts(bus_priv, bus_addr[6:2]) && (!m_ov || q_ready)) ld = 1;
        end else if (bus_priv) begin
          case ({bus_addr[11:2], 2'b00})
            12'h100: m_en   = bus_wdata;
            12'h140: m_lock = bus_wdata[3:0];
            12'h180: m_gen  = bus_wdata[0];
            default: ;
          endcase
        end
      end
      if (ld) begin
        m_ov = 1; m_port = bus_addr[6:2]; m_data = bus_wdata;
      end else if (q_ready) begin
        m_ov = 0;
      end
    end
  end

  // compare output stage against the model each cycle
  always @(negedge clk) begin
    #2;
    if (mon_on) begin
      chk("R9 q_valid", {31'd0, q_valid}, {31'd0, m_ov});
      if (m_ov) begin
        chk("R2 q_port", {27'd0, q_port}, {27'd0, m_port});
        chk("R2 q_data", q_data, m_data);
      end
    end
  end

  task automatic bus_write(input logic priv, input logic [11:0] a,
                           input logic [31:0] d, input int hold, input string tag);
    int cnt;
    logic w;
    cnt = 0;
    do begin
      @(negedge clk);
      if (cnt == hold) q_ready = 1'b1;
      bus_sel = 1; bus_wr = 1; bus_priv = priv; bus_addr = a; bus_wdata = d;
      #1;
      chk(tag, {31'd0, bus_wait}, {31'd0, exp_wait()});
      w = bus_wait;
      @(posedge clk);
      cnt++;
    end while (w && cnt < 50);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic priv, input logic [11:0] a,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_priv = priv; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    chk({tag, " model"}, bus_rdata, exp_rdata());
    @(posedge clk);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_priv = 0;
    bus_addr = 0; bus_wdata = 0; q_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);
    mon_on = 1;

    // R1 reset state
    chk("R1 q_valid", {31'd0, q_valid}, 32'd0);
    bus_read(1, 12'h100, 32'd0, "R1 enable");
    bus_read(1, 12'h140, 32'd0, "R1 lock");
    bus_read(1, 12'h180, 32'd0, "R1 ctrl");

    // R8 unprivileged config writes ignored
    bus_write(0, 12'h180, 32'h1, -1, "R8 wait");
    bus_write(0, 12'h100, 32'hFFFF_FFFF, -1, "R8 wait");
    bus_read(1, 12'h180, 32'd0, "R8 ctrl");
    bus_read(1, 12'h100, 32'd0, "R8 enable");

    // R4 master disabled: dropped, no wait
    bus_write(1, 12'h100, 32'hFFFF_FFFF, -1, "R3 cfg");
    bus_write(1, 12'h014, 32'hDEAD_0001, -1, "R4 wait");
    chk("R4 no forward", {31'd0, q_valid}, 32'd0);

    // R2 forward with port tag
    bus_write(1, 12'h180, 32'h1, -1, "R4 cfg");
    bus_write(1, 12'h014, 32'hA5A5_0005, -1, "R2 wait");

    // R3 per-port enable
    bus_write(1, 12'h100, 32'hFFFF_FF0F, -1, "R3 cfg");
    bus_write(1, 12'h014, 32'h0000_0BAD, -1, "R3 wait");
    bus_write(1, 12'h007, 32'h1111_0001, -1, "R2 wait");

    // R5 group privilege lock
    bus_write(1, 12'h140, 32'h2, -1, "R5 cfg");
    bus_write(0, 12'h024, 32'h0000_0BAD, -1, "R5 unpriv wait");
    bus_write(1, 12'h024, 32'h9999_0009, -1, "R5 priv wait");
    bus_write(0, 12'h050, 32'h2020_0014, -1, "R5 other group");

    // R7 masked enable read
    bus_read(0, 12'h100, 32'hFFFF_000F, "R7 unpriv");
    bus_read(1, 12'h100, 32'hFFFF_FF0F, "R7 priv");
    bus_read(0, 12'h140, 32'h2, "R5 lock read");

    // R6 stimulus read, unprivileged, locked group, ready
    bus_read(0, 12'h024, 32'h1, "R6 ready");

    // R9 stall and ordering
    q_ready = 0;
    bus_write(1, 12'h000, 32'hD1D1_0000, -1, "R9 first");
    bus_read(0, 12'h000, 32'h0, "R6 full");
    bus_write(1, 12'h004, 32'hD2D2_0001, 3, "R9 stall");
    chk("R9 second loaded", q_data, 32'hD2D2_0001);

    // R10 dropped write while full
    q_ready = 0;
    bus_write(1, 12'h000, 32'hD3D3_0000, -1, "R9 load");
    bus_write(1, 12'h014, 32'h0000_0BAD, -1, "R10 wait");
    bus_write(0, 12'h020, 32'h0000_0BAD, -1, "R10 locked wait");
    q_ready = 1;
    repeat (2) @(posedge clk);

    // R2 unmapped read
    bus_read(1, 12'h200, 32'd0, "R2 unmapped");
    bus_read(1, 12'h7FC, 32'd0, "R2 unmapped");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule